// File: doc/BRIEF.md
# Memory-Mapped Single-Lane SPI NOR Flash Controller

This block lets a processor reach one serial NOR flash device through a small register set and a memory window. A single bus port with a request/ready handshake carries both kinds of access. A select line chooses between the register file and the flash window. A further line chooses between byte and word size.

In user mode, software builds SPI commands by hand. It frames the chip select through a stop bit in the control register. Each byte written to the window is shifted out on MOSI. Each window read sends 0xFF and returns what MISO carried.

In the three direct modes, one window access becomes a complete SPI command, framed by its own chip-select pulse. The command starts with the opcode held in the control register. Next come the flash address, which is the window offset, as three or four bytes. Fast read adds one dummy byte after the address. The data bytes follow. Every shift runs in SPI mode 0, with SCLK derived from the system clock by a divider parameter. The bus access is held until the last bit has been shifted.

Top module: `spi_nor_mmctl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and all three registers read 0.
- R2: The registers are selected by bus_addr[3:2] when bus_win is 0:
  - 0 is the configuration register. Its bit 16 enables window writes.
  - 1 is the address-width register. Its bit 0 selects 4-byte addressing.
  - 2 is the control register. Its bits [1:0] hold the mode (0 read, 1 fast read, 2 write, 3 user), bit 2 is the stop bit and bits [23:16] hold the opcode.
  - Only these bits are stored. All other bits read as 0.
- R3: When the mode is 3, spi_cs_n equals the stop bit. Software asserts chip select by clearing the stop bit and releases it by setting the stop bit.
- R4: In user mode, a byte write shifts wdata[7:0] out MSB first. A byte read shifts out 0xFF and returns the captured byte in rdata[7:0], with rdata[31:8] = 0.
- R5: A word access in user mode shifts 4 bytes, bus byte 0 first: wdata[7:0] is sent first. The first byte received lands in rdata[7:0] and the fourth in rdata[31:24].
- R6: Mode 0 with a word read sends the following, inside one chip-select low period that ends before bus_ready:
  - the opcode;
  - address bits [23:16], [15:8] and [7:0], where the address is the window offset;
  - four 0xFF bytes, while the returned data is captured in bus byte order.
- R7: With the address-width bit set, direct commands send four address bytes, starting with bits [31:24].
- R8: Mode 1 inserts one 0xFF dummy byte between the address and the data bytes.
- R9: Mode 2 with a word write sends the opcode, then the address, then wdata bytes 0 to 3.
- R10: When configuration bit 16 is 0, a window write completes on the bus with no SCLK edge and no chip-select pulse. Window reads still work.
- R11: SCLK idles low and has a period of 2*CLK_DIV clock cycles within a byte. bus_ready for a window access comes no sooner than 16*CLK_DIV cycles per shifted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_win | input | 1 | 1 for flash window, 0 for registers |
| bus_word | input | 1 | 1 for 32-bit access, 0 for byte access |
| bus_addr | input | AW | Register offset or window offset |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Direct commands are driven with random opcodes, random word-aligned offsets and random data. Each of read, fast read and write is tried with both address widths and with both access sizes, so a wrong address byte count, a missing dummy byte or a reversed data byte order shows up as a stream mismatch. MISO returns a position-dependent byte pattern with a fresh base for each access, which separates a correct capture order from a shifted or swapped one. Directed cases cover the chip-select framing in user mode, locked writes in both direct and user mode, and two consecutive reads whose address bytes must follow the offset.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    MODE_RD   = 2'd0,
    MODE_FRD  = 2'd1,
    MODE_WR   = 2'd2,
    MODE_USER = 2'd3
  } xfer_mode_e;

  localparam logic [1:0] SEL_CFG   = 2'd0;
  localparam logic [1:0] SEL_AWIDE = 2'd1;
  localparam logic [1:0] SEL_CTL   = 2'd2;

  localparam int CFG_WWE_BIT  = 16;
  localparam int CTL_STOP_BIT = 2;
  localparam int CTL_OP_LSB   = 16;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        win_we_ok,
  output logic        addr4,
  output xfer_mode_e  mode,
  output logic        stop,
  output logic [7:0]  opcode
);
  logic       wwe_q, wwe_d;
  logic       a4_q, a4_d;
  xfer_mode_e mode_q, mode_d;
  logic       stop_q, stop_d;
  logic [7:0] op_q, op_d;

  always_comb begin
    wwe_d  = wwe_q;
    a4_d   = a4_q;
    mode_d = mode_q;
    stop_d = stop_q;
    op_d   = op_q;
    if (wr) begin
      case (sel)
        SEL_CFG:   wwe_d = wdata[CFG_WWE_BIT];
        SEL_AWIDE: a4_d  = wdata[0];
        SEL_CTL: begin
          mode_d = xfer_mode_e'(wdata[1:0]);
          stop_d = wdata[CTL_STOP_BIT];
          op_d   = wdata[CTL_OP_LSB +: 8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wwe_q  <= 1'b0;
      a4_q   <= 1'b0;
      mode_q <= MODE_RD;
      stop_q <= 1'b0;
      op_q   <= 8'h00;
    end else begin
      wwe_q  <= wwe_d;
      a4_q   <= a4_d;
      mode_q <= mode_d;
      stop_q <= stop_d;
      op_q   <= op_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CFG:   rdata[CFG_WWE_BIT] = wwe_q;
      SEL_AWIDE: rdata[0] = a4_q;
      SEL_CTL: begin
        rdata[1:0]              = mode_q;
        rdata[CTL_STOP_BIT]     = stop_q;
        rdata[CTL_OP_LSB +: 8]  = op_q;
      end
      default: ;
    endcase
  end

  assign win_we_ok = wwe_q;
  assign addr4     = a4_q;
  assign mode      = mode_q;
  assign stop      = stop_q;
  assign opcode    = op_q;
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DTOP = DW'(CLK_DIV - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          sclk_q, sclk_d;
  logic [DW-1:0] div_q, div_d;
  logic [3:0]    half_q, half_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    rx_q, rx_d;
  logic          tick;

  assign tick = busy_q && (div_q == DTOP);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sclk_d = sclk_q;
    div_d  = div_q;
    half_d = half_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = tx;
        div_d  = '0;
        half_d = '0;
        sclk_d = 1'b0;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sclk_d = ~sclk_q;
        half_d = half_q + 4'd1;
        if (!sclk_q) begin
          rx_d = {rx_q[6:0], miso};
        end else begin
          sh_d = {sh_q[6:0], 1'b1};
        end
        if (half_q == 4'd15) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      half_q <= '0;
      sh_q   <= 8'hFF;
      rx_q   <= 8'h00;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sclk_q <= sclk_d;
      div_q  <= div_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sclk = sclk_q;
  assign mosi = sh_q[7];

  // R11: SCLK only moves at the end of a divider count
  p_sclk_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> $past(div_q) == DTOP);
  // R11: SCLK rests low outside a byte
  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          bus_win,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  xfer_mode_e    mode,
  input  logic [7:0]    opcode,
  input  logic          addr4,
  input  logic          win_we_ok,
  input  logic [31:0]   reg_rdata,
  output logic          reg_wr,
  output logic          sh_start,
  output logic [7:0]    sh_tx,
  input  logic          sh_done,
  input  logic          sh_busy,
  input  logic [7:0]    sh_rx,
  output logic [31:0]   rdata,
  output logic          ready,
  output logic          dir_cs_n,
  output logic          busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_DONE} st_e;

  st_e         st_q, st_d;
  logic [47:0] cmd_q, cmd_d;
  logic [31:0] dat_q, dat_d;
  logic [3:0]  idx_q, idx_d;
  logic [3:0]  last_q, last_d;
  logic [2:0]  ncmd_q, ncmd_d;
  logic        we_q, we_d;
  logic        cs_q, cs_d;
  logic [31:0] a32;
  logic [1:0]  didx;
  logic        in_cmd;
  logic [7:0]  cmd_byte, dat_byte;
  logic        direct;
  logic [2:0]  ncmd_new;

  assign a32    = 32'(bus_addr);
  assign direct = (mode != MODE_USER);
  assign in_cmd = idx_q < {1'b0, ncmd_q};
  assign didx   = 2'(idx_q - {1'b0, ncmd_q});

  always_comb begin
    ncmd_new = 3'd0;
    if (direct) begin
      ncmd_new = 3'd1 + (addr4 ? 3'd4 : 3'd3) + ((mode == MODE_FRD) ? 3'd1 : 3'd0);
    end
  end

  always_comb begin
    cmd_byte = IDLE_BYTE;
    for (int i = 0; i < 6; i++) begin
      if (idx_q[2:0] == 3'(i)) cmd_byte = cmd_q[47 - 8*i -: 8];
    end
    dat_byte = IDLE_BYTE;
    for (int j = 0; j < 4; j++) begin
      if (didx == 2'(j) && we_q) dat_byte = dat_q[8*j +: 8];
    end
  end

  assign sh_tx = in_cmd ? cmd_byte : dat_byte;

  always_comb begin
    st_d     = st_q;
    cmd_d    = cmd_q;
    dat_d    = dat_q;
    idx_d    = idx_q;
    last_d   = last_q;
    ncmd_d   = ncmd_q;
    we_d     = we_q;
    cs_d     = cs_q;
    reg_wr   = 1'b0;
    sh_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (bus_req) begin
          if (!bus_win) begin
            reg_wr = bus_we;
            if (!bus_we) dat_d = reg_rdata;
            st_d = ST_DONE;
          end else if (bus_we && !win_we_ok) begin
            st_d = ST_DONE;
          end else begin
            ncmd_d = ncmd_new;
            last_d = {1'b0, ncmd_new} + (bus_word ? 4'd3 : 4'd0);
            we_d   = bus_we;
            dat_d  = bus_we ? bus_wdata : 32'h0;
            cmd_d  = addr4 ? {opcode, a32, IDLE_BYTE}
                           : {opcode, a32[23:0], IDLE_BYTE, IDLE_BYTE};
            idx_d  = 4'd0;
            cs_d   = !direct;
            st_d   = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        sh_start = 1'b1;
        st_d     = ST_WAIT;
      end
      ST_WAIT: begin
        if (sh_done) begin
          if (!in_cmd && !we_q) dat_d[8*didx +: 8] = sh_rx;
          if (idx_q == last_q) begin
            cs_d = 1'b1;
            st_d = ST_DONE;
          end else begin
            idx_d = idx_q + 4'd1;
            st_d  = ST_LOAD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      dat_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      ncmd_q <= '0;
      we_q   <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      dat_q  <= dat_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      ncmd_q <= ncmd_d;
      we_q   <= we_d;
      cs_q   <= cs_d;
    end
  end

  assign rdata    = dat_q;
  assign ready    = (st_q == ST_DONE);
  assign dir_cs_n = cs_q;
  assign busy     = (st_q != ST_IDLE);

  // R6: a direct command has released chip select by completion
  p_ready_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> cs_q);
  // R10: a locked window write goes straight to completion
  p_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && bus_req && bus_win && bus_we && !win_we_ok)
      |=> (st_q == ST_DONE && !sh_busy));
  // R11: a new byte is only started on an idle shifter
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);
endmodule

// File: rtl/spi_nor_mmctl.sv
module spi_nor_mmctl
  import sfc_pkg::*;
#(
  parameter int AW      = 26,
  parameter int CLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          bus_win,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_ready,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  logic        reg_wr;
  logic [31:0] reg_rdata;
  logic        win_we_ok, addr4, stop;
  xfer_mode_e  mode;
  logic [7:0]  opcode;
  logic        sh_start, sh_done, sh_busy;
  logic [7:0]  sh_tx, sh_rx;
  logic        dir_cs_n, seq_busy;
  logic        user_frame;

  sfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(bus_addr[3:2]),
    .wdata(bus_wdata), .rdata(reg_rdata), .win_we_ok(win_we_ok),
    .addr4(addr4), .mode(mode), .stop(stop), .opcode(opcode)
  );

  sfc_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_win(bus_win), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode(mode), .opcode(opcode), .addr4(addr4),
    .win_we_ok(win_we_ok), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done),
    .sh_busy(sh_busy), .sh_rx(sh_rx), .rdata(bus_rdata),
    .ready(bus_ready), .dir_cs_n(dir_cs_n), .busy(seq_busy)
  );

  sfc_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  assign user_frame = (mode == MODE_USER) && !stop;
  assign spi_cs_n   = dir_cs_n && !user_frame;

  // R3: in user mode chip select never comes from the command sequencer
  p_user_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_USER) |-> dir_cs_n);
  // R11: no shifting while the sequencer is idle
  p_shift_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> seq_busy);
endmodule

// File: tb/spi_nor_mmctl_test.sv
`timescale 1ns/1ps
module spi_nor_mmctl_test;
  localparam int AW  = 26;
  localparam int DIV = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0, bus_word = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_ready, spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0, fails = 0;
  bit finished = 0;

  spi_nor_mmctl #(.AW(AW), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_win(bus_win), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  // SPI-side monitor and MISO pattern source
  logic [7:0] mon_bytes [16];
  int         mon_n = 0, mon_bits = 0, cs_hi_bits = 0, per_bad = 0, cs_falls = 0;
  logic [7:0] cur = 8'h00;
  logic [7:0] miso_seed = 8'h00;
  longint     last_rise = 0;
  logic [7:0] cur_pat;

  function automatic logic [7:0] pat(input int k);
    return miso_seed + 8'(k * 41);
  endfunction

  assign cur_pat  = pat(mon_n);
  assign spi_miso = cur_pat[3'd7 - 3'(mon_bits)];

  always @(posedge spi_sclk) begin
    if (spi_cs_n) cs_hi_bits++;
    if (mon_bits != 0 && ($time - last_rise) != 2 * DIV * 8) per_bad++;
    last_rise = $time;
    cur = {cur[6:0], spi_mosi};
    if (mon_bits == 7) begin
      if (mon_n < 16) mon_bytes[mon_n] = cur;
      mon_n++;
      mon_bits = 0;
    end else begin
      mon_bits++;
    end
  end

  always @(negedge spi_cs_n) cs_falls++;

  task automatic mon_clear();
    mon_n = 0; mon_bits = 0; cs_hi_bits = 0; per_bad = 0; cs_falls = 0;
    miso_seed = 8'($urandom);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic win, input logic we, input logic word,
                        input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_win = win; bus_we = we; bus_word = word;
    bus_addr = AW'(addr); bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ready && cyc < 5000);
    rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; bus_win = 1'b0;
  endtask

  task automatic reg_wr(input int sel, input logic [31:0] v);
    logic [31:0] rd; int c;
    bus_op(1'b0, 1'b1, 1'b1, 32'(sel * 4), v, rd, c);
  endtask

  task automatic reg_rd(input int sel, output logic [31:0] rd);
    int c;
    bus_op(1'b0, 1'b0, 1'b1, 32'(sel * 4), 32'h0, rd, c);
  endtask

  // expected MOSI stream for one window access
  logic [7:0] exp_b [16];
  int         exp_n, exp_ncmd;

  task automatic build_exp(input int mode, input bit a4, input logic [7:0] op,
                           input logic [31:0] a, input bit word, input bit we,
                           input logic [31:0] wd);
    exp_n = 0;
    if (mode != 3) begin
      exp_b[exp_n++] = op;
      if (a4) exp_b[exp_n++] = a[31:24];
      exp_b[exp_n++] = a[23:16];
      exp_b[exp_n++] = a[15:8];
      exp_b[exp_n++] = a[7:0];
      if (mode == 1) exp_b[exp_n++] = 8'hFF;
    end
    exp_ncmd = exp_n;
    for (int j = 0; j < (word ? 4 : 1); j++)
      exp_b[exp_n++] = we ? wd[8*j +: 8] : 8'hFF;
  endtask

  function automatic logic [31:0] exp_rdata(input bit word);
    logic [31:0] r = '0;
    for (int j = 0; j < (word ? 4 : 1); j++) r[8*j +: 8] = pat(exp_ncmd + j);
    return r;
  endfunction

  task automatic check_stream(input string req);
    int bad = 0;
    if (mon_n != exp_n) bad = 1;
    else for (int k = 0; k < exp_n; k++) if (mon_bytes[k] != exp_b[k]) bad++;
    check(bad == 0, req, 32'(mon_n), 32'(exp_n));
  endtask

  // one direct-mode access with all checks
  task automatic direct_access(input int mode, input bit a4, input logic [7:0] op,
                               input logic [31:0] a, input bit word, input bit we,
                               input logic [31:0] wd, input string req);
    logic [31:0] rd; int cyc;
    reg_wr(1, {31'b0, a4});
    reg_wr(2, {8'h00, op, 13'b0, 1'b0, 2'(mode)});
    build_exp(mode, a4, op, a, word, we, wd);
    mon_clear();
    bus_op(1'b1, we, word, a, wd, rd, cyc);
    check_stream(req);
    if (!we) check(rd == exp_rdata(word), req, rd, exp_rdata(word));
    check(cs_falls == 1 && cs_hi_bits == 0 && spi_cs_n, "R6", 32'(cs_falls), 32'd1);
    check(per_bad == 0 && cyc >= exp_n * 16 * DIV, "R11", 32'(cyc), 32'(exp_n * 16 * DIV));
  endtask

  initial begin
    logic [31:0] rd; int cyc;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", {spi_cs_n, spi_sclk}, 32'h2);
    rst_n = 1'b1;
    for (int s = 0; s < 3; s++) begin
      reg_rd(s, rd);
      check(rd == 32'h0, "R1", rd, 32'h0);
    end
    // R2: register fields and readback masks
    reg_wr(0, 32'hFFFF_FFFF); reg_rd(0, rd);
    check(rd == 32'h0001_0000, "R2", rd, 32'h0001_0000);
    reg_wr(1, 32'hFFFF_FFFF); reg_rd(1, rd);
    check(rd == 32'h0000_0001, "R2", rd, 32'h0000_0001);
    reg_wr(2, 32'hFFFF_FFFF); reg_rd(2, rd);
    check(rd == 32'h00FF_0007, "R2", rd, 32'h00FF_0007);
    reg_rd(3, rd);
    check(rd == 32'h0, "R2", rd, 32'h0);
    reg_wr(1, 32'h0);

    // R3: user-mode framing
    reg_wr(2, 32'h0000_0007);
    check(spi_cs_n == 1'b1, "R3", {31'b0, spi_cs_n}, 32'h1);
    reg_wr(2, 32'h0000_0003);
    check(spi_cs_n == 1'b0, "R3", {31'b0, spi_cs_n}, 32'h0);
    // R4: user byte write and byte read
    build_exp(3, 0, 8'h00, 0, 0, 1, 32'h0000_009F);
    mon_clear();
    bus_op(1'b1, 1'b1, 1'b0, 32'h0, 32'hAAAA_AA9F, rd, cyc);
    check_stream("R4");
    build_exp(3, 0, 8'h00, 0, 0, 0, 0);
    mon_clear();
    bus_op(1'b1, 1'b0, 1'b0, 32'h0, 32'h0, rd, cyc);
    check_stream("R4");
    check(rd == exp_rdata(0), "R4", rd, exp_rdata(0));
    // R5: user word write and read byte order
    build_exp(3, 0, 8'h00, 0, 1, 1, 32'h1122_3344);
    mon_clear();
    bus_op(1'b1, 1'b1, 1'b1, 32'h0, 32'h1122_3344, rd, cyc);
    check_stream("R5");
    check(cs_hi_bits == 0 && spi_cs_n == 1'b0, "R3", 32'(cs_hi_bits), 32'h0);
    build_exp(3, 0, 8'h00, 0, 1, 0, 0);
    mon_clear();
    bus_op(1'b1, 1'b0, 1'b1, 32'h0, 32'h0, rd, cyc);
    check_stream("R5");
    check(rd == exp_rdata(1), "R5", rd, exp_rdata(1));
    reg_wr(2, 32'h0000_0007);
    check(spi_cs_n == 1'b1, "R3", {31'b0, spi_cs_n}, 32'h1);

    // R10: locked writes in user and direct write mode
    reg_wr(0, 32'h0);
    reg_wr(2, 32'h0000_0003);
    mon_clear();
    bus_op(1'b1, 1'b1, 1'b1, 32'h0, 32'hDEAD_BEEF, rd, cyc);
    check(mon_n == 0 && mon_bits == 0 && cyc < 8, "R10", 32'(mon_bits), 32'h0);
    reg_wr(2, 32'h0002_0002);
    mon_clear();
    bus_op(1'b1, 1'b1, 1'b1, 32'h100, 32'hDEAD_BEEF, rd, cyc);
    check(mon_bits == 0 && mon_n == 0 && cs_falls == 0, "R10",
          32'(cs_falls), 32'h0);
    // R10: reads still go out while writes are locked
    direct_access(0, 0, 8'h03, 32'h100, 1, 0, 0, "R10");
    reg_wr(0, 32'h0001_0000);

    // R6: consecutive word reads follow the offset
    direct_access(0, 0, 8'h03, 32'h0002_0100, 1, 0, 0, "R6");
    direct_access(0, 0, 8'h03, 32'h0002_0104, 1, 0, 0, "R6");
    // R7: 4-byte address with high bits set
    direct_access(0, 1, 8'h13, 32'h03FF_FFFC, 1, 0, 0, "R7");
    // R8: fast read with both widths
    direct_access(1, 0, 8'h0B, 32'h0012_3450, 1, 0, 0, "R8");
    direct_access(1, 1, 8'h0C, 32'h0212_3450, 1, 0, 0, "R8");
    // R9: direct write
    direct_access(2, 0, 8'h02, 32'h0000_0040, 1, 1, 32'hABCD_EF12, "R9");

    // random direct accesses
    for (int it = 0; it < 40; it++) begin
      int          m  = int'($urandom_range(0, 2));
      bit          a4 = 1'($urandom);
      bit          wd = 1'($urandom);
      logic [7:0]  op = 8'($urandom);
      logic [31:0] a  = $urandom & ((32'h1 << AW) - 1) & ~32'h3;
      logic [31:0] d  = $urandom;
      string       tag;
      tag = (m == 2) ? "R9" : (m == 1) ? "R8" : a4 ? "R7" : "R6";
      direct_access(m, a4, op, a, wd, (m == 2), d, tag);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule